// File: doc/BRIEF.md
# Pipelined burst cache SRAM

A synthesizable, cycle-accurate model of a synchronous pipelined burst SRAM. Words are 18 bits wide, split into two 9-bit byte lanes, and the depth is a parameter. An access is opened by one of two start strobes. The processor-side strobe always opens a read. The controller-side strobe opens a read or a write, depending on the write enables sampled on the same edge. An internal 2-bit beat counter then walks the remaining words of a 4-word group. It moves on each edge that samples the advance strobe low. The order is linear or XOR-interleaved, chosen by a static pin.

Read data passes through two registers before it reaches the data pins. The pins are driven only while output enable is low, no write has just been sampled, and the device is awake. A sleep input freezes all state. After sleep is released, two further edges are spent waking up, and no access is accepted on them.

Top module: `pipe_burst_ram`

## Requirements
- R1: After reset, `dq_drive` is low and no burst is open.
- R2: On an edge where `proc_start_n` is low and all three chip selects are active, a read burst opens at `addr`. On that edge `ctrl_start_n`, `adv_n` and every write enable are ignored.
- R3: `proc_start_n` has no effect while `cs1_n` is high. On such an edge, `ctrl_start_n` alone decides whether a burst starts.
- R4: `ctrl_start_n` opens a burst only on an edge where `proc_start_n` is high (or is blocked by R3). The write enables sampled on that same edge make it a write burst that stores `dq_in` at `addr`.
- R5: Each beat address is `{addr[AW-1:2], lo}`. With `order_sel` low, `lo = (addr[1:0] + n) mod 4`. With `order_sel` high, `lo = addr[1:0] ^ n`. Here `n` is the number of advances since the start, modulo 4, so the sequence returns to its first word after four beats.
- R6: On an edge where a burst is open and neither strobe starts or ends it, the beat counter steps when `adv_n` is low and holds when `adv_n` is high. The access on that edge uses the resulting beat. A write edge is handled the same way as a read edge.
- R7: `gwr_n` low writes both lanes, whatever the values of `bwr_en_n` and `lane_we_n`. With `gwr_n` high and `bwr_en_n` low, lane i (bits 9i+8..9i) is written exactly when `lane_we_n[i]` is low. Any other combination is a read.
- R8: Data read on edge k is presented on `dq_out` after edge k+1.
- R9: For the cycle after an edge that performs a write, `dq_drive` stays low whatever `oe_n` is. Otherwise `oe_n` high forces `dq_drive` low combinationally.
- R10: A strobe that would start a burst while `cs2` is low or `cs3_n` is high closes any open burst. Nothing further is read, and the outputs fall silent once the pipeline drains.
- R11: While `sleep` is high, no state or memory word changes and `dq_drive` is low. On the first two edges after `sleep` falls, no access of any kind is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | AW | Word address, sampled on start edges |
| proc_start_n | input | 1 | Processor-side burst start, active low |
| ctrl_start_n | input | 1 | Controller-side burst start, active low |
| adv_n | input | 1 | Beat advance, active low |
| cs1_n | input | 1 | Chip select 1, active low |
| cs2 | input | 1 | Chip select 2, active high |
| cs3_n | input | 1 | Chip select 3, active low |
| gwr_n | input | 1 | Global write, all lanes, active low |
| bwr_en_n | input | 1 | Qualifies the per-lane enables, active low |
| lane_we_n | input | LANES | Per-lane write enables, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| order_sel | input | 1 | Beat order: 0 linear, 1 interleaved |
| sleep | input | 1 | Power-down request, active high |
| dq_in | input | W | Write data |
| dq_out | output | W | Read data |
| dq_drive | output | 1 | High when `dq_out` would be driven on the pins |

## Verification
The bench aims at the edges where the two strobes collide. The processor strobe with write enables low must still read; a design that obeyed the enables would corrupt memory. A controller start must write on its very first edge; a design that waited one edge would lose the first word. It also runs bursts that start at every offset in both orders and hold on suspend cycles. Wrong wrap logic there would read a word outside the 4-word group, or the wrong word inside it. Finally it drives sleep, with start strobes on the two wake-up edges, and deselects through chip selects 2 and 3 mid-burst. A design that honoured the early strobes, or let a deselected burst run on, would drive data where a silent bus is expected.

// File: rtl/pipe_burst_ram.sv
module pipe_burst_ram #(
  parameter int DEPTH = 64,
  parameter int LANE  = 9,
  parameter int LANES = 2,
  localparam int AW = $clog2(DEPTH),
  localparam int W  = LANE * LANES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  input  logic             proc_start_n,
  input  logic             ctrl_start_n,
  input  logic             adv_n,
  input  logic             cs1_n,
  input  logic             cs2,
  input  logic             cs3_n,
  input  logic             gwr_n,
  input  logic             bwr_en_n,
  input  logic [LANES-1:0] lane_we_n,
  input  logic             oe_n,
  input  logic             order_sel,
  input  logic             sleep,
  input  logic [W-1:0]     dq_in,
  output logic [W-1:0]     dq_out,
  output logic             dq_drive
);

  logic [W-1:0]    mem [DEPTH];
  logic            act, s1v, ov, whold;
  logic [AW-3:0]   base;
  logic [1:0]      seed, beat, wake;
  logic [W-1:0]    s1d, od;

  wire blocked   = (wake != 2'd0);
  wire sel       = !cs1_n && cs2 && !cs3_n;
  wire p_go      = !proc_start_n && !cs1_n;
  wire c_go      = !ctrl_start_n && (proc_start_n || cs1_n);
  wire start_try = !blocked && (p_go || c_go);
  wire start_ok  = start_try && sel;
  wire cont      = !blocked && !p_go && !c_go && act;

  wire [LANES-1:0] lanes_req = !gwr_n ? {LANES{1'b1}} :
                               (!bwr_en_n ? ~lane_we_n : {LANES{1'b0}});
  wire [LANES-1:0] wl = ((start_ok && c_go) || cont) ? lanes_req : {LANES{1'b0}};

  wire [1:0]    off_use  = start_ok ? 2'd0 : (!adv_n ? beat + 2'd1 : beat);
  wire [1:0]    seed_use = start_ok ? addr[1:0] : seed;
  wire [AW-3:0] base_use = start_ok ? addr[AW-1:2] : base;
  wire [1:0]    lo       = order_sel ? (seed_use ^ off_use) : (seed_use + off_use);
  wire [AW-1:0] acc_addr = {base_use, lo};

  wire do_acc = start_ok || cont;
  wire do_wr  = do_acc && (|wl);
  wire do_rd  = do_acc && !(|wl);

  always_ff @(posedge clk) begin
    if (do_wr && !sleep)
      for (int i = 0; i < LANES; i++)
        if (wl[i]) mem[acc_addr][i*LANE +: LANE] <= dq_in[i*LANE +: LANE];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act   <= 1'b0;
      base  <= '0;
      seed  <= 2'd0;
      beat  <= 2'd0;
      s1v   <= 1'b0;
      s1d   <= '0;
      ov    <= 1'b0;
      od    <= '0;
      whold <= 1'b0;
      wake  <= 2'd0;
    end else if (sleep) begin
      wake <= 2'd2;
    end else begin
      if (blocked) wake <= wake - 2'd1;
      if (start_ok) begin
        act  <= 1'b1;
        base <= addr[AW-1:2];
        seed <= addr[1:0];
        beat <= 2'd0;
      end else if (start_try) begin
        act <= 1'b0;
      end else if (cont && !adv_n) begin
        beat <= beat + 2'd1;
      end
      s1v <= do_rd;
      if (do_rd) s1d <= mem[acc_addr];
      ov    <= s1v;
      od    <= s1d;
      whold <= do_wr;
    end
  end

  assign dq_out   = od;
  assign dq_drive = ov && !oe_n && !whold && !sleep;

endmodule

// File: rtl/pipe_burst_ram_chk.sv
module pipe_burst_ram_chk (
  input logic clk,
  input logic rst_n,
  input logic sleep,
  input logic proc_start_n,
  input logic cs1_n,
  input logic cs2,
  input logic s1v,
  input logic ov,
  input logic act,
  input logic do_wr,
  input logic dq_drive
);

  assert_pipe_stage_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (s1v && !sleep) |=> ov);

  assert_write_hides_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (do_wr && !sleep) |=> !dq_drive);

  assert_deselect_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !proc_start_n && !cs1_n && !cs2) |=> !s1v);

  assert_wake_guard_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleep) |=> !s1v);

  assert_sleep_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> ($stable(act) && $stable(ov)));

endmodule

bind pipe_burst_ram pipe_burst_ram_chk chk_i (
  .clk(clk), .rst_n(rst_n), .sleep(sleep), .proc_start_n(proc_start_n),
  .cs1_n(cs1_n), .cs2(cs2), .s1v(s1v), .ov(ov), .act(act),
  .do_wr(do_wr), .dq_drive(dq_drive)
);

// File: tb/tb_pipe_burst_ram.sv
module tb_pipe_burst_ram;
  localparam int DEPTH = 64;
  localparam int AW = 6;
  localparam int W = 18;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n;
  logic [AW-1:0] addr;
  logic proc_n, ctrl_n, adv_n, cs1_n, cs2, cs3_n, gwr_n, bwr_n, oe_n, order_sel, sleep;
  logic [1:0] lane_n;
  logic [W-1:0] din, dq_out;
  logic dq_drive;

  pipe_burst_ram #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .proc_start_n(proc_n), .ctrl_start_n(ctrl_n),
    .adv_n(adv_n), .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n), .gwr_n(gwr_n),
    .bwr_en_n(bwr_n), .lane_we_n(lane_n), .oe_n(oe_n), .order_sel(order_sel),
    .sleep(sleep), .dq_in(din), .dq_out(dq_out), .dq_drive(dq_drive)
  );

  int n_cmp = 0, n_bad = 0;
  string tag = "R1";

  logic [W-1:0] rmem [DEPTH];
  bit rknown [DEPTH];
  bit m_act, m_s1v, m_s1k, m_ov, m_ok, m_wh;
  logic [AW-3:0] m_base;
  logic [1:0] m_seed, m_beat;
  logic [W-1:0] m_s1d, m_od;
  int m_wake;

  function automatic logic [1:0] beat_lo(input logic [1:0] s, input logic [1:0] n, input logic ord);
    return ord ? (s ^ n) : (s + n);
  endfunction

  function automatic logic [1:0] lanes_of(input logic g, input logic b, input logic [1:0] l);
    if (!g) return 2'b11;
    if (!b) return ~l;
    return 2'b00;
  endfunction

  task automatic model_edge();
    logic sel, pgo, cgo, blk, stok, cont, rd, wr;
    logic [1:0] wl;
    logic [AW-1:0] a;
    if (sleep) begin m_wake = 2; return; end
    blk = (m_wake != 0);
    if (m_wake != 0) m_wake--;
    sel  = !cs1_n && cs2 && !cs3_n;
    pgo  = !proc_n && !cs1_n;
    cgo  = !ctrl_n && (proc_n || cs1_n);
    stok = !blk && (pgo || cgo) && sel;
    cont = !blk && !pgo && !cgo && m_act;
    wl = lanes_of(gwr_n, bwr_n, lane_n);
    if (stok && pgo) wl = 2'b00;
    if (!stok && !cont) wl = 2'b00;
    if (!blk && (pgo || cgo) && !sel) m_act = 0;
    if (stok) begin
      m_act = 1; m_base = addr[AW-1:2]; m_seed = addr[1:0]; m_beat = 0;
    end else if (cont && !adv_n) m_beat = m_beat + 2'd1;
    a = {m_base, beat_lo(m_seed, m_beat, order_sel)};
    rd = (stok || cont) && wl == 2'b00;
    wr = (stok || cont) && wl != 2'b00;
    m_ov = m_s1v; m_od = m_s1d; m_ok = m_s1k;
    m_s1v = rd;
    if (rd) begin m_s1d = rmem[a]; m_s1k = rknown[a]; end
    if (wr) begin
      if (wl[0]) rmem[a][8:0] = din[8:0];
      if (wl[1]) rmem[a][17:9] = din[17:9];
      if (wl == 2'b11) rknown[a] = 1;
    end
    m_wh = wr;
  endtask

  task automatic compare();
    bit ed;
    ed = m_ov && !oe_n && !m_wh && !sleep;
    n_cmp++;
    if (dq_drive !== ed) begin
      n_bad++;
      $display("FAIL %s drive: actual %0b expected %0b at %0t", tag, dq_drive, ed, $time);
    end
    if (ed && m_ok) begin
      n_cmp++;
      if (dq_out !== m_od) begin
        n_bad++;
        $display("FAIL %s data: actual %h expected %h at %0t", tag, dq_out, m_od, $time);
      end
    end
  endtask

  task automatic tick();
    model_edge();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic idle_in();
    proc_n = 1; ctrl_n = 1; adv_n = 1; cs1_n = 0; cs2 = 1; cs3_n = 0;
    gwr_n = 1; bwr_n = 1; lane_n = 2'b11; oe_n = 0; sleep = 0; din = '0;
  endtask

  task automatic drain(input int k);
    for (int i = 0; i < k; i++) begin idle_in(); tick(); end
  endtask

  task automatic read_burst(input logic [AW-1:0] a, input logic ord, input logic [3:0] advs);
    idle_in(); order_sel = ord; proc_n = 0; addr = a; gwr_n = 0; ctrl_n = 0; adv_n = 0; tick();
    for (int i = 0; i < 4; i++) begin idle_in(); adv_n = advs[i]; tick(); end
    drain(2);
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    idle_in(); order_sel = 0; addr = '0; rst_n = 0;
    m_act = 0; m_s1v = 0; m_s1k = 0; m_ov = 0; m_ok = 0; m_wh = 0;
    m_base = '0; m_seed = 0; m_beat = 0; m_s1d = '0; m_od = '0; m_wake = 0;
    for (int i = 0; i < DEPTH; i++) begin rmem[i] = '0; rknown[i] = 0; end
    repeat (3) @(negedge clk);
    tag = "R1";
    compare();
    rst_n = 1;
    @(negedge clk);
    compare();

    // R4 R7: controller-start write bursts fill memory, first word on the start edge
    tag = "R4";
    for (int k = 0; k < DEPTH / 4; k++) begin
      idle_in(); ctrl_n = 0; addr = AW'(4 * k); gwr_n = 0; din = W'($urandom); tick();
      for (int j = 0; j < 3; j++) begin
        idle_in(); adv_n = 0; bwr_n = 0; lane_n = 2'b00; din = W'($urandom); tick();
      end
    end
    drain(2);

    // R2 R8 R5: processor-start reads at every offset, both orders
    for (int o = 0; o < 4; o++) begin
      tag = "R2"; read_burst(AW'(8 + o), 1'b0, 4'b0000);
      tag = "R5"; read_burst(AW'(20 + o), 1'b1, 4'b0000);
    end
    tag = "R8";
    read_burst(AW'(33), 1'b0, 4'b1111);

    // R6: suspend in the middle of bursts
    tag = "R6";
    read_burst(AW'(42), 1'b0, 4'b0101);
    read_burst(AW'(47), 1'b1, 4'b1010);

    // R7: byte-lane writes, then read back
    tag = "R7";
    idle_in(); ctrl_n = 0; addr = AW'(12); bwr_n = 0; lane_n = 2'b10; din = 18'h2A5A5; tick();
    idle_in(); adv_n = 0; bwr_n = 0; lane_n = 2'b01; din = 18'h15A5A; tick();
    idle_in(); adv_n = 0; gwr_n = 0; bwr_n = 1; lane_n = 2'b11; din = 18'h3C3C3; tick();
    idle_in(); adv_n = 0; bwr_n = 1; lane_n = 2'b00; din = 18'h0FFFF; tick();
    drain(2);
    read_burst(AW'(12), 1'b0, 4'b1000);

    // R12-style edge: write enables ignored on processor start, honoured after (R2 R6)
    tag = "R6";
    idle_in(); proc_n = 0; addr = AW'(16); gwr_n = 0; tick();
    idle_in(); adv_n = 0; gwr_n = 0; din = 18'h12345; tick();
    drain(2);
    read_burst(AW'(16), 1'b0, 4'b1110);

    // R3: processor strobe blocked by cs1_n high; controller start with it
    tag = "R3";
    idle_in(); proc_n = 0; cs1_n = 1; addr = AW'(28); tick();
    drain(3);
    idle_in(); proc_n = 0; ctrl_n = 0; cs1_n = 1; addr = AW'(28); tick();
    drain(3);
    read_burst(AW'(24), 1'b0, 4'b0000);
    idle_in(); proc_n = 0; cs1_n = 1; adv_n = 0; addr = AW'(0); tick();
    drain(3);

    // R9: output enable gating and write-after-read
    tag = "R9";
    idle_in(); proc_n = 0; addr = AW'(36); tick();
    idle_in(); adv_n = 0; tick();
    idle_in(); adv_n = 0; oe_n = 1; tick();
    idle_in(); adv_n = 0; gwr_n = 0; din = 18'h00777; tick();
    idle_in(); oe_n = 0; tick();
    drain(2);

    // R10: deselect through cs2 and cs3_n mid-burst
    tag = "R10";
    idle_in(); proc_n = 0; addr = AW'(52); tick();
    idle_in(); adv_n = 0; tick();
    idle_in(); proc_n = 0; cs2 = 0; addr = AW'(4); tick();
    idle_in(); adv_n = 0; tick();
    drain(3);
    idle_in(); ctrl_n = 0; addr = AW'(56); tick();
    idle_in(); ctrl_n = 0; cs3_n = 1; tick();
    idle_in(); adv_n = 0; gwr_n = 0; din = 18'h3FFFF; tick();
    drain(3);
    read_burst(AW'(56), 1'b0, 4'b0000);

    // R11: sleep freeze and two-edge wake guard
    tag = "R11";
    idle_in(); proc_n = 0; addr = AW'(60); tick();
    idle_in(); adv_n = 0; tick();
    idle_in(); sleep = 1; adv_n = 0; proc_n = 0; tick();
    idle_in(); sleep = 1; ctrl_n = 0; gwr_n = 0; tick();
    idle_in(); proc_n = 0; addr = AW'(0); tick();
    idle_in(); ctrl_n = 0; gwr_n = 0; addr = AW'(1); din = 18'h11111; tick();
    idle_in(); adv_n = 0; tick();
    drain(3);
    read_burst(AW'(0), 1'b0, 4'b0000);

    // mixed random traffic
    tag = "random";
    for (int c = 0; c < 3000; c++) begin
      proc_n = ($urandom % 7) != 0;
      ctrl_n = ($urandom % 7) != 0;
      adv_n = $urandom % 2;
      cs1_n = ($urandom % 12) == 0;
      cs2 = ($urandom % 12) != 0;
      cs3_n = ($urandom % 12) == 0;
      gwr_n = ($urandom % 5) != 0;
      bwr_n = $urandom % 2;
      lane_n = 2'($urandom);
      oe_n = ($urandom % 6) == 0;
      sleep = ($urandom % 60) == 0;
      if (c % 64 == 0) order_sel = $urandom % 2;
      addr = AW'($urandom);
      din = W'($urandom);
      tick();
    end
    drain(3);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule